// File: doc/BRIEF.md
# Serial Divide-Ratio Loader

This block takes a three-wire serial word (data, shift clock, load strobe) and uses it to program the two divide ratios of a frequency synthesizer. One ratio is the main feedback divider, held as a 12-bit counter value and a 6-bit swallow value. The other is the 14-bit reference divider. The serial pins are sampled in the system clock domain, so they must already be synchronous to `clk` and must stay at each level for at least two system cycles. Every frame ends with one steering bit. That bit decides which of the two holding registers takes the word when the load strobe rises. The other register keeps its contents.

Bits move through a 19-position chain, most significant bit first. The newest bit always sits in the steering position, and the 18 positions above it hold the ratio payload. A main frame therefore needs 19 shift clocks and a reference frame needs 15. Any extra leading bits simply fall off the top of the chain.

The block has no flow-data interface, so it has no valid/ready pair. Each update is reported by a one-cycle pulse per register, with no back-pressure: the downstream counters must accept the new ratio in the cycle the pulse is high.

Top module: `divset_loader`

## Requirements
- R1: On each system cycle where `ser_clk_i` is seen rising, the chain shifts one place toward its top and the value of `ser_dat_i` enters the steering position (chain bit 0).
- R2: When `ser_le_i` is seen rising and the steering bit is 0, the main register loads: `cnt_o` takes chain bits 18..7 (the first 12 bits sent) and `swl_o` takes chain bits 6..1.
- R3: When `ser_le_i` is seen rising and the steering bit is 1, `ref_o` takes chain bits 14..1, which are the 14 bits sent just before the steering bit.
- R4: If more bits are clocked in than the frame needs, only the most recent 19 (main frame) or 15 (reference frame) bits affect the loaded value.
- R5: A load changes only the selected register. The other register's output keeps its value.
- R6: Shifting bits with `ser_le_i` low changes no output.
- R7: Each load gives exactly one one-cycle pulse on `main_upd_o` or `ref_upd_o`, in the same cycle the new value appears. Holding `ser_le_i` high for a long time does not give a second pulse. The two pulses are never high together.
- R8: While `rst_n` is low, the outputs are `cnt_o`=DEF_CNT (100), `swl_o`=DEF_SWL (0) and `ref_o`=DEF_REF (5), both pulses are low, and the chain is cleared.
- R9: Raising `ser_le_i` again without any new bits reloads the same register with the same word and pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial shift clock, sampled by `clk` |
| ser_dat_i | input | 1 | Serial data, most significant bit first, steering bit last |
| ser_le_i | input | 1 | Load strobe; its rising edge commits the chain to one register |
| cnt_o | output | 12 | Main divider counter value |
| swl_o | output | 6 | Main divider swallow value |
| ref_o | output | 14 | Reference divider value |
| main_upd_o | output | 1 | One-cycle pulse when `cnt_o`/`swl_o` update |
| ref_upd_o | output | 1 | One-cycle pulse when `ref_o` updates |

## Verification
The main path is tested with main and reference frames of exact length and with frames that carry extra leading bits. This shows whether the right chain window is taken for each register. Frames with all-ones and minimum payloads expose swapped or truncated fields. Alternating main and reference loads show whether the unselected register really holds its value. Directed cases cover four more situations: bits shifted with no load, a load strobe held high for a long time, a repeated strobe with no new bits, and reset in the middle of a run.

// File: rtl/divset_pkg.sv
package divset_pkg;
  localparam int SWL_W   = 6;
  localparam int CNT_W   = 12;
  localparam int REF_W   = 14;
  localparam int MAIN_W  = SWL_W + CNT_W;
  localparam int CHAIN_W = MAIN_W + 1;

  typedef enum logic {
    SEL_MAIN = 1'b0,
    SEL_REF  = 1'b1
  } sel_e;
endpackage

// File: rtl/divset_edge.sv
module divset_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  // prev resets high so a pin already high at reset release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sig_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/divset_shift.sv
module divset_shift
  import divset_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              dat_i,
  output logic [MAIN_W-1:0] payload_o,
  output sel_e              steer_o
);
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       chain_q <= '0;
    else if (shift_i) chain_q <= {chain_q[CHAIN_W-2:0], dat_i};
  end

  assign payload_o = chain_q[CHAIN_W-1:1];
  assign steer_o   = sel_e'(chain_q[0]);

  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> (chain_q[0] == $past(dat_i)) &&
                (chain_q[CHAIN_W-1:1] == $past(chain_q[CHAIN_W-2:0])));
  assert_shift_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(chain_q));
endmodule

// File: rtl/divset_latch.sv
module divset_latch #(
  parameter int          W   = 14,
  parameter logic [W-1:0] DEF = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o,
  output logic         upd_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o   <= DEF;
      upd_o <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i) q_o <= din_i;
    end
  end

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(q_o));
  assert_latch_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_o == $past(din_i)));
endmodule

// File: rtl/divset_loader.sv
module divset_loader
  import divset_pkg::*;
#(
  parameter logic [CNT_W-1:0] DEF_CNT = 12'd100,
  parameter logic [SWL_W-1:0] DEF_SWL = 6'd0,
  parameter logic [REF_W-1:0] DEF_REF = 14'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_le_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SWL_W-1:0] swl_o,
  output logic [REF_W-1:0] ref_o,
  output logic             main_upd_o,
  output logic             ref_upd_o
);
  logic [1:0]        rise;
  logic              sclk_rise, le_rise;
  logic [MAIN_W-1:0] payload;
  sel_e              steer;
  logic              load_main, load_ref;
  logic [MAIN_W-1:0] main_word;

  divset_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .sig_i({ser_le_i, ser_clk_i}),
    .rise_o(rise)
  );
  assign sclk_rise = rise[0];
  assign le_rise   = rise[1];

  divset_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_i(sclk_rise), .dat_i(ser_dat_i),
    .payload_o(payload), .steer_o(steer)
  );

  // steering bit gated by the load edge picks exactly one register
  assign load_main = le_rise && (steer == SEL_MAIN);
  assign load_ref  = le_rise && (steer == SEL_REF);

  divset_latch #(.W(MAIN_W), .DEF({DEF_CNT, DEF_SWL})) u_main (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_main), .din_i(payload),
    .q_o(main_word), .upd_o(main_upd_o)
  );

  divset_latch #(.W(REF_W), .DEF(DEF_REF)) u_ref (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_ref), .din_i(payload[REF_W-1:0]),
    .q_o(ref_o), .upd_o(ref_upd_o)
  );

  assign cnt_o = main_word[MAIN_W-1:SWL_W];
  assign swl_o = main_word[SWL_W-1:0];

  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_upd_o, ref_upd_o}));
  assert_main_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    main_upd_o |=> !main_upd_o);
  assert_ref_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd_o |=> !ref_upd_o);
  assert_ref_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    main_upd_o |-> $stable(ref_o));
  assert_main_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd_o |-> ($stable(cnt_o) && $stable(swl_o)));
endmodule

// File: tb/divset_loader_bench.sv
`timescale 1ns/1ps
module divset_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [11:0] cnt;
  logic [5:0]  swl;
  logic [13:0] refv;
  logic        mupd, rupd;

  int checks = 0, failures = 0;
  int n_main = 0, n_ref = 0;
  logic [18:0] exp_chain = '0;
  logic [11:0] exp_cnt = 12'd100;
  logic [5:0]  exp_swl = 6'd0;
  logic [13:0] exp_ref = 14'd5;

  always #5 clk = ~clk;

  divset_loader u_divset_loader (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
    .cnt_o(cnt), .swl_o(swl), .ref_o(refv),
    .main_upd_o(mupd), .ref_upd_o(rupd)
  );

  always @(posedge clk) begin
    if (mupd) n_main <= n_main + 1;
    if (rupd) n_ref  <= n_ref + 1;
  end

  // frame bits right-aligned, sent MSB first; last bit is the steering bit
  localparam int NV = 6;
  localparam logic [31:0] VBITS [NV] = '{
    {13'd0, 12'd300,  6'd17, 1'b0},
    {17'd0, 14'd1234, 1'b1},
    {9'd0,  4'hF, 12'd4095, 6'd63, 1'b0},
    {17'd0, 14'd16383, 1'b1},
    {12'd0, 5'h1F, 14'd5, 1'b1},
    {13'd0, 12'd5, 6'd0, 1'b0}
  };
  localparam int VLEN [NV] = '{19, 15, 23, 15, 20, 19};
  localparam string VREQ [NV] = '{"R2", "R3", "R4", "R3", "R4", "R2"};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] bits, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk);
      sdat = bits[i];
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      exp_chain = {exp_chain[17:0], bits[i]};
    end
  endtask

  task automatic pulse_le(input int hold);
    @(negedge clk);
    sle = 1'b1;
    repeat (hold) @(negedge clk);
    sle = 1'b0;
    repeat (3) @(negedge clk);
    if (exp_chain[0] == 1'b0) begin
      exp_cnt = exp_chain[18:7];
      exp_swl = exp_chain[6:1];
    end else begin
      exp_ref = exp_chain[14:1];
    end
  endtask

  task automatic check_outs(input string req);
    check(cnt == exp_cnt, req, "cnt", cnt, exp_cnt);
    check(swl == exp_swl, req, "swl", swl, exp_swl);
    check(refv == exp_ref, req, "ref", refv, exp_ref);
  endtask

  task automatic check_pulses(input string req, input int m0, input int r0,
                              input int dm, input int dr);
    check(n_main - m0 == dm, req, "main pulses", n_main - m0, dm);
    check(n_ref - r0 == dr, req, "ref pulses", n_ref - r0, dr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int m0, r0;
    repeat (4) @(negedge clk);
    // R8 reset state
    check(cnt == 12'd100, "R8", "reset cnt", cnt, 100);
    check(swl == 6'd0, "R8", "reset swl", swl, 0);
    check(refv == 14'd5, "R8", "reset ref", refv, 5);
    check(!mupd && !rupd, "R8", "reset pulses", {mupd, rupd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      send_bits(VBITS[v], VLEN[v]);
      m0 = n_main; r0 = n_ref;
      pulse_le(2);
      check_outs(VREQ[v]);
      check_outs("R5");
      check_pulses("R7", m0, r0, (exp_chain[0] == 1'b0) ? 1 : 0,
                   (exp_chain[0] == 1'b1) ? 1 : 0);
    end

    // R6: shift a full main frame with load strobe low
    m0 = n_main; r0 = n_ref;
    send_bits({13'd0, 12'd777, 6'd9, 1'b0}, 19);
    repeat (3) @(negedge clk);
    check_outs("R6");
    check_pulses("R6", m0, r0, 0, 0);

    // R1/R7: now load it with a long-held strobe, exactly one pulse
    m0 = n_main; r0 = n_ref;
    pulse_le(12);
    check(cnt == 12'd777 && swl == 6'd9, "R1", "shifted word",
          {cnt, swl}, {12'd777, 6'd9});
    check_pulses("R7", m0, r0, 1, 0);

    // R9: strobe again without new bits
    m0 = n_main; r0 = n_ref;
    pulse_le(2);
    check_outs("R9");
    check_pulses("R9", m0, r0, 1, 0);

    // R5: reference load leaves main word in place
    send_bits({17'd0, 14'd42, 1'b1}, 15);
    pulse_le(2);
    check(refv == 14'd42, "R3", "ref", refv, 42);
    check(cnt == 12'd777 && swl == 6'd9, "R5", "main kept",
          {cnt, swl}, {12'd777, 6'd9});

    // R8: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(cnt == 12'd100 && swl == 6'd0 && refv == 14'd5, "R8", "mid reset",
          {cnt, swl, refv}, {12'd100, 6'd0, 14'd5});
    rst_n = 1'b1;
    exp_chain = '0;
    exp_cnt = 12'd100; exp_swl = 6'd0; exp_ref = 14'd5;
    // cleared chain steers to main with a zero payload
    pulse_le(2);
    check(cnt == 12'd0 && swl == 6'd0, "R8", "cleared chain",
          {cnt, swl}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule